// File: doc/BRIEF.md
# SIMT Divergence Lane Mask Stack

This block keeps track of which lanes of a wide SIMD engine are active while nested if/else regions run. A comparison unit hands in one condition bit per lane. The instruction sequencer then issues one of three commands: open a region, switch to its else side, or close it. The block stores the enclosing masks on a small stack. It drives the current active mask, which gates per-lane register writeback.

When a region opens, its mask is the condition ANDed with the enclosing mask. The else side takes the inverse of the region mask ANDed with the saved enclosing mask, so lanes that were off before the region stay off. Closing a region restores the enclosing mask. Two one-cycle flags tell the sequencer that a then-side or an else-side has no active lane, so that it can skip that region. Pushing onto a full stack sets a sticky overflow error. Popping or switching to else with nothing on the stack sets a sticky underflow error. A per-lane blend stage shows how the mask is applied: every lane produces a result, and lanes whose mask bit is 0 keep their old value.

Top module: `simt_mask_stack`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has an all-ones `active_mask_o`, `depth_o` at 0, and `overflow_o`, `underflow_o`, `cond_none_o` and `else_empty_o` all at 0.
- R2: A push (`cmd_i` = 2'b01) with `depth_o` below `DEPTH` makes `active_mask_o` equal to `cond_i` AND the previous mask, and raises `depth_o` by one, from the next clock edge.
- R3: A push with `depth_o` equal to `DEPTH` sets `overflow_o`, which stays set until reset, and leaves the mask and depth unchanged.
- R4: An else (`cmd_i` = 2'b10) with `depth_o` above 0 makes the mask equal to the inverse of the current mask AND the mask saved by the matching push. Depth is unchanged.
- R5: A pop (`cmd_i` = 2'b11) with `depth_o` above 0 restores the mask saved by the matching push and lowers the depth by one. At depth 0 the mask is all ones.
- R6: An else or a pop with `depth_o` at 0 sets `underflow_o`, which stays set until reset, and leaves the mask and depth unchanged.
- R7: `cond_none_o` is high for exactly the one cycle after an accepted push whose resulting mask is all zero. It is low at all other times.
- R8: `else_empty_o` is high for exactly the one cycle after an accepted else whose resulting mask is all zero. It is low at all other times.
- R9: For each lane i, the `DATA_W`-bit field i of `wb_data_o` equals field i of `wb_new_i` when mask bit i is 1, and field i of `wb_old_i` when it is 0.
- R10: An idle command (`cmd_i` = 2'b00) leaves the mask, the depth and both errors unchanged. Only one command is taken per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 00 idle, 01 push, 10 else, 11 pop |
| cond_i | input | LANES | Per-lane condition from the comparison unit |
| wb_new_i | input | LANES*DATA_W | Newly computed lane results |
| wb_old_i | input | LANES*DATA_W | Current destination lane values |
| active_mask_o | output | LANES | Current active lane mask |
| depth_o | output | $clog2(DEPTH+1) | Current nesting depth |
| cond_none_o | output | 1 | Last push produced an empty mask |
| else_empty_o | output | 1 | Last else produced an empty mask |
| overflow_o | output | 1 | Sticky push-when-full error |
| underflow_o | output | 1 | Sticky else/pop-when-empty error |
| wb_data_o | output | LANES*DATA_W | Writeback data after per-lane masking |

## Verification
The bench builds the block with `LANES`=4, `DEPTH`=3 and `DATA_W`=4. With four lanes, every pair of outer and inner condition vectors can be swept: 256 nested push/push/else/pop/else/pop sequences. This covers every combination of the enclosing mask, the region mask and the else result, including the empty results that raise the skip flags. With a depth of three, the full-stack overflow and the empty-stack underflow are reached within a few commands. The full three-level unwind is checked against masks computed per lane in the bench.

// File: rtl/mstk_pkg.sv
package mstk_pkg;
  typedef enum logic [1:0] {
    MC_IDLE = 2'b00,
    MC_PUSH = 2'b01,
    MC_ELSE = 2'b10,
    MC_POP  = 2'b11
  } mstk_cmd_e;
endpackage

// File: rtl/mstk_store.sv
module mstk_store #(
  parameter int LANES = 16,
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LANES-1:0] wr_mask,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [LANES-1:0] rd_mask
);
  logic [LANES-1:0] slot [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(e))) slot[e] <= wr_mask;
    end
  end

  always_comb begin
    rd_mask = '1;
    for (int e = 0; e < DEPTH; e++) begin
      if (rd_idx == IDX_W'(e)) rd_mask = slot[e];
    end
  end
endmodule

// File: rtl/mstk_ctrl.sv
module mstk_ctrl
  import mstk_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       cmd,
  output logic             do_push,
  output logic             do_else,
  output logic             do_pop,
  output logic             ovf_evt,
  output logic             unf_evt,
  output logic [PTR_W-1:0] depth,
  output logic             overflow,
  output logic             underflow
);
  mstk_cmd_e op;
  logic      full, empty;

  assign op    = mstk_cmd_e'(cmd);
  assign full  = (depth == PTR_W'(DEPTH));
  assign empty = (depth == '0);

  assign do_push = (op == MC_PUSH) && !full;
  assign do_else = (op == MC_ELSE) && !empty;
  assign do_pop  = (op == MC_POP)  && !empty;
  assign ovf_evt = (op == MC_PUSH) && full;
  assign unf_evt = ((op == MC_ELSE) || (op == MC_POP)) && empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      depth     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (do_push)      depth <= depth + PTR_W'(1);
      else if (do_pop)  depth <= depth - PTR_W'(1);
      if (ovf_evt) overflow  <= 1'b1;
      if (unf_evt) underflow <= 1'b1;
    end
  end
endmodule

// File: rtl/mstk_blend.sv
module mstk_blend #(
  parameter int LANES  = 16,
  parameter int DATA_W = 32
) (
  input  logic [LANES-1:0]        lane_en,
  input  logic [LANES*DATA_W-1:0] new_val,
  input  logic [LANES*DATA_W-1:0] old_val,
  output logic [LANES*DATA_W-1:0] out_val
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign out_val[l*DATA_W +: DATA_W] =
      lane_en[l] ? new_val[l*DATA_W +: DATA_W] : old_val[l*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int LANES  = 16,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              cmd_i,
  input  logic [LANES-1:0]        cond_i,
  input  logic [LANES*DATA_W-1:0] wb_new_i,
  input  logic [LANES*DATA_W-1:0] wb_old_i,
  output logic [LANES-1:0]        active_mask_o,
  output logic [PTR_W-1:0]        depth_o,
  output logic                    cond_none_o,
  output logic                    else_empty_o,
  output logic                    overflow_o,
  output logic                    underflow_o,
  output logic [LANES*DATA_W-1:0] wb_data_o
);
  // Mask arithmetic kept in functions so it reads as the rule it implements.
  function automatic logic [LANES-1:0] enter_region(logic [LANES-1:0] cond,
                                                    logic [LANES-1:0] cur);
    return cond & cur;
  endfunction

  function automatic logic [LANES-1:0] flip_region(logic [LANES-1:0] region,
                                                   logic [LANES-1:0] parent);
    return ~region & parent;
  endfunction

  // Named internal events, also observed by the checker.
  logic             do_push, do_else, do_pop, ovf_evt, unf_evt;
  logic [LANES-1:0] parent_mask;
  logic [LANES-1:0] next_mask;
  logic [PTR_W-1:0] below_top;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  mstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .cmd(cmd_i),
    .do_push(do_push), .do_else(do_else), .do_pop(do_pop),
    .ovf_evt(ovf_evt), .unf_evt(unf_evt),
    .depth(depth_o), .overflow(overflow_o), .underflow(underflow_o)
  );

  assign below_top = depth_o - PTR_W'(1);
  assign wr_idx    = IDX_W'(depth_o);
  assign rd_idx    = IDX_W'(below_top);

  mstk_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(do_push), .wr_idx(wr_idx), .wr_mask(active_mask_o),
    .rd_idx(rd_idx), .rd_mask(parent_mask)
  );

  always_comb begin
    next_mask = active_mask_o;
    if (do_push)      next_mask = enter_region(cond_i, active_mask_o);
    else if (do_else) next_mask = flip_region(active_mask_o, parent_mask);
    else if (do_pop)  next_mask = parent_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_mask_o <= '1;
      cond_none_o   <= 1'b0;
      else_empty_o  <= 1'b0;
    end else begin
      active_mask_o <= next_mask;
      cond_none_o   <= do_push && (next_mask == '0);
      else_empty_o  <= do_else && (next_mask == '0);
    end
  end

  mstk_blend #(.LANES(LANES), .DATA_W(DATA_W)) u_blend (
    .lane_en(active_mask_o), .new_val(wb_new_i), .old_val(wb_old_i),
    .out_val(wb_data_o)
  );
endmodule

// File: rtl/mstk_chk.sv
module mstk_chk #(
  parameter int LANES  = 16,
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic [1:0]              cmd_i,
  input logic [LANES-1:0]        cond_i,
  input logic [LANES*DATA_W-1:0] wb_new_i,
  input logic [LANES*DATA_W-1:0] wb_old_i,
  input logic [LANES-1:0]        active_mask_o,
  input logic [PTR_W-1:0]        depth_o,
  input logic                    cond_none_o,
  input logic                    else_empty_o,
  input logic                    overflow_o,
  input logic                    underflow_o,
  input logic [LANES*DATA_W-1:0] wb_data_o,
  input logic                    do_push,
  input logic                    do_else,
  input logic                    ovf_evt,
  input logic                    unf_evt
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (&active_mask_o && depth_o == '0 && !overflow_o && !underflow_o
             && !cond_none_o && !else_empty_o));

  assert_push_and_R2: assert property (@(posedge clk) disable iff (rst)
    do_push |=> (active_mask_o == ($past(cond_i) & $past(active_mask_o))));

  assert_push_deeper_R2: assert property (@(posedge clk) disable iff (rst)
    do_push |=> (depth_o == $past(depth_o) + PTR_W'(1)));

  assert_no_overflow_change_R3: assert property (@(posedge clk) disable iff (rst)
    ovf_evt |=> (overflow_o && $stable(active_mask_o) && $stable(depth_o)));

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    overflow_o |=> overflow_o);

  assert_else_disjoint_R4: assert property (@(posedge clk) disable iff (rst)
    do_else |=> ((active_mask_o & $past(active_mask_o)) == '0 && $stable(depth_o)));

  assert_empty_all_ones_R5: assert property (@(posedge clk) disable iff (rst)
    (depth_o == '0) |-> &active_mask_o);

  assert_no_underflow_change_R6: assert property (@(posedge clk) disable iff (rst)
    unf_evt |=> (underflow_o && $stable(active_mask_o) && $stable(depth_o)));

  assert_underflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    underflow_o |=> underflow_o);

  assert_cond_none_R7: assert property (@(posedge clk) disable iff (rst)
    do_push |=> (cond_none_o == (active_mask_o == '0)));

  assert_cond_none_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !do_push |=> !cond_none_o);

  assert_else_empty_R8: assert property (@(posedge clk) disable iff (rst)
    do_else |=> (else_empty_o == (active_mask_o == '0)));

  assert_else_empty_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    !do_else |=> !else_empty_o);

  assert_lane0_blend_R9: assert property (@(posedge clk) disable iff (rst)
    wb_data_o[DATA_W-1:0] ==
      (active_mask_o[0] ? wb_new_i[DATA_W-1:0] : wb_old_i[DATA_W-1:0]));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cmd_i == 2'b00) |=> ($stable(active_mask_o) && $stable(depth_o)
                          && $stable(overflow_o) && $stable(underflow_o)));
endmodule

bind simt_mask_stack mstk_chk #(
  .LANES(LANES), .DEPTH(DEPTH), .DATA_W(DATA_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst(rst), .cmd_i(cmd_i), .cond_i(cond_i),
  .wb_new_i(wb_new_i), .wb_old_i(wb_old_i),
  .active_mask_o(active_mask_o), .depth_o(depth_o),
  .cond_none_o(cond_none_o), .else_empty_o(else_empty_o),
  .overflow_o(overflow_o), .underflow_o(underflow_o), .wb_data_o(wb_data_o),
  .do_push(do_push), .do_else(do_else), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
);

// File: tb/tb_simt_mask_stack.sv
`timescale 1ns/1ps
module tb_simt_mask_stack;
  localparam int NL = 4;
  localparam int ND = 3;
  localparam int DW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] cmd = 2'b00;
  logic [NL-1:0] cond = '0;
  logic [NL*DW-1:0] wb_new = '0, wb_old = '0;
  logic [NL-1:0] mask;
  logic [1:0] depth;
  logic cn, ee, ovf, unf;
  logic [NL*DW-1:0] wb_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  simt_mask_stack #(.LANES(NL), .DEPTH(ND), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .cmd_i(cmd), .cond_i(cond),
    .wb_new_i(wb_new), .wb_old_i(wb_old),
    .active_mask_o(mask), .depth_o(depth), .cond_none_o(cn),
    .else_empty_o(ee), .overflow_o(ovf), .underflow_o(unf), .wb_data_o(wb_out)
  );

  // Reference model
  logic [NL-1:0] m_stk [ND];
  logic [NL-1:0] m_mask;
  int m_depth;
  bit m_ovf, m_unf, m_cn, m_ee;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mask = '1; m_depth = 0; m_ovf = 0; m_unf = 0; m_cn = 0; m_ee = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cmd = 2'b00;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
    #1;
    check("R1 mask", 64'(mask), 64'hF);
    check("R1 depth", 64'(depth), 0);
    check("R1 flags", {ovf, unf, cn, ee}, 0);
  endtask

  function automatic bit none_set(logic [NL-1:0] v);
    for (int i = 0; i < NL; i++) if (v[i]) return 0;
    return 1;
  endfunction

  task automatic step(input logic [1:0] c, input logic [NL-1:0] cv);
    logic [NL-1:0] nm;
    logic [NL*DW-1:0] exp_wb;
    string tag;
    @(negedge clk);
    cmd = c; cond = cv;
    wb_new = {4{cv}} ^ 16'h5A3C;
    wb_old = {cv, ~cv, cv, ~cv} ^ 16'hC3A5;
    m_cn = 0; m_ee = 0; nm = m_mask;
    case (c)
      2'b01: begin
        tag = "R2";
        if (m_depth == ND) begin m_ovf = 1; tag = "R3"; end
        else begin
          for (int i = 0; i < NL; i++) nm[i] = cv[i] && m_mask[i];
          m_stk[m_depth] = m_mask; m_depth++; m_cn = none_set(nm);
        end
      end
      2'b10: begin
        tag = "R4";
        if (m_depth == 0) begin m_unf = 1; tag = "R6"; end
        else begin
          for (int i = 0; i < NL; i++) nm[i] = !m_mask[i] && m_stk[m_depth-1][i];
          m_ee = none_set(nm);
        end
      end
      2'b11: begin
        tag = "R5";
        if (m_depth == 0) begin m_unf = 1; tag = "R6"; end
        else begin m_depth--; nm = m_stk[m_depth]; end
      end
      default: tag = "R10";
    endcase
    m_mask = nm;
    @(posedge clk); #2;
    check({tag, " mask"}, 64'(mask), 64'(m_mask));
    check({tag, " depth"}, 64'(depth), 64'(m_depth));
    check("R3 overflow", 64'(ovf), 64'(m_ovf));
    check("R6 underflow", 64'(unf), 64'(m_unf));
    check("R7 cond_none", 64'(cn), 64'(m_cn));
    check("R8 else_empty", 64'(ee), 64'(m_ee));
    for (int i = 0; i < NL; i++)
      exp_wb[i*DW +: DW] = m_mask[i] ? wb_new[i*DW +: DW] : wb_old[i*DW +: DW];
    check("R9 blend", 64'(wb_out), 64'(exp_wb));
  endtask

  initial begin
    model_reset();
    do_reset();
    step(2'b00, 4'h5);  // R10 idle at depth 0
    // Exhaustive nested sweep: R2 R4 R5 R7 R8 R9
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        step(2'b01, 4'(a));
        step(2'b01, 4'(b));
        step(2'b00, 4'(a ^ b));  // R10 idle inside region
        step(2'b10, 4'(b));
        step(2'b11, 4'(a));
        step(2'b10, 4'(a));
        step(2'b11, 4'(b));
      end
    end
    // R3 overflow at full depth, then full unwind
    step(2'b01, 4'hE);
    step(2'b01, 4'h7);
    step(2'b01, 4'hF);
    step(2'b01, 4'h0);
    step(2'b00, 4'h0);
    step(2'b10, 4'h0);
    step(2'b11, 4'h0);
    step(2'b11, 4'h0);
    step(2'b11, 4'h0);
    check("R3 overflow kept", 64'(ovf), 1);
    do_reset();
    // R6 underflow on empty stack
    step(2'b11, 4'h3);
    step(2'b10, 4'h3);
    step(2'b01, 4'h9);
    step(2'b11, 4'h0);
    step(2'b11, 4'h0);
    check("R6 underflow kept", 64'(unf), 1);
    do_reset();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule